// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates five interrupt sources of a small 8-bit core: two external lines, two timer overflows and one serial port. Software programs two byte-wide registers. One holds the per-source enables and a master enable. The other holds a per-source level bit that selects low or high. A machine-cycle strobe marks the sampling point. On that clock the controller captures the request flags. In the machine cycle that follows it polls them. When an eligible request wins, it asks the core for a forced long call to a fixed vector.

Two in-service flags, one for each level, implement the nesting rules. A high-level request may interrupt a low-level handler. Nothing interrupts a high-level handler. A low-level request must wait until no low-level handler is active. The core signals the end of a handler with a return strobe, which clears the in-service flag of the level in charge. The core saves the program counter and handles the stack.

Top module: `irq_vec_ctrl`

## Requirements
- R1: The enable register (`cfg_sel`=0) uses bit 0 for external 0, bit 1 for timer 0, bit 2 for external 1, bit 3 for timer 1, bit 4 for serial, and bit 7 as master enable. A 1 enables the source. Bits 6 and 5 are ignored.
- R2: While the master enable is 0, no call is issued, whatever the per-source bits hold.
- R3: The level register (`cfg_sel`=1) maps sources to bits 0..4 in the same order as R1. A 1 selects high level. Bits 7..5 are ignored.
- R4: A high-level request may interrupt a low-level handler. A low-level request never interrupts a low-level handler. No request interrupts a high-level handler.
- R5: Requests are captured only on a clock where `phase_s5` is 1. A grant from that capture shows as `call_req` high two clocks after that edge. A request that is present only between strobes is never served.
- R6: Among simultaneous eligible requests, high level beats low level. Within one level, the order is external 0, timer 0, external 1, timer 1, serial.
- R7: The vector is 0x0003 + 8×index, with index 0..4 in the order of R6. That gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R8: `reti_i` clears the high in-service flag if it is set, and otherwise the low one. With neither flag set, it has no effect.
- R9: No call is issued from a poll cycle in which `reti_i` or `cfg_wr` is asserted. The request is reconsidered at the next machine cycle.
- R10: `call_req` is high for one clock per grant. `call_vec` is valid while `call_req` is high and is 0 otherwise. Both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_s5 | input | 1 | Sampling strobe, one clock per machine cycle |
| req_i | input | 5 | Request flags, one bit per source in R6 order |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the enable register, 1 selects the level register |
| cfg_wdata | input | 8 | Write data |
| reti_i | input | 1 | Return-from-handler strobe |
| call_req | output | 1 | Forced long-call request, one clock wide |
| call_vec | output | 16 | Call target address |

## Verification
A return strobe or a register write can land in the same clock as the poll of a pending request. The bench steers a write onto the clock right after the sampling strobe and checks that the call moves to the following machine cycle instead of being lost or issued with the old settings. It also issues a return while both levels are in service. The clear must hit only the high flag, so a waiting low request stays blocked until a second return. A behavioural model predicts `call_req` and `call_vec` on every clock and compares them with the design's outputs.

// File: rtl/irqc_pkg.sv
// Shared definitions for the two-level interrupt controller.
// Assumes at most 8 sources, so a source index fits in 3 bits.
package irqc_pkg;
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } irq_lvl_e;

    typedef enum logic {
        CFG_ENABLE   = 1'b0,
        CFG_PRIORITY = 1'b1
    } cfg_target_e;
endpackage

// File: rtl/irqc_cfg_regs.sv
// Enable and level registers.
// Stores only the source bits and the master enable.
// Reserved write bits are dropped.
module irqc_cfg_regs #(
    parameter int SRC_N      = 5,
    parameter int CFG_W      = 8,
    parameter int GLOBAL_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CFG_W-1:0] wr_data,
    output logic [SRC_N-1:0] src_en,
    output logic             glob_en,
    output logic [SRC_N-1:0] src_hi
);
    import irqc_pkg::*;

    // Capture writes to whichever register wr_sel names.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en  <= '0;
            glob_en <= 1'b0;
            src_hi  <= '0;
        end else if (wr_en) begin
            if (cfg_target_e'(wr_sel) == CFG_ENABLE) begin
                src_en  <= wr_data[SRC_N-1:0];
                glob_en <= wr_data[GLOBAL_BIT];
            end else begin
                src_hi  <= wr_data[SRC_N-1:0];
            end
        end
    end
endmodule

// File: rtl/irqc_sampler.sv
// Latches the request flags on the sampling strobe.
// Raises the poll flag for the clock that follows.
// Assumes phase_s5 is a one-clock pulse per machine cycle.
module irqc_sampler #(
    parameter int SRC_N = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_s5,
    input  logic [SRC_N-1:0] req_i,
    output logic [SRC_N-1:0] pend_q,
    output logic             poll_q
);
    // Hold the last sampled flags; mark the next clock as the poll slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            poll_q <= 1'b0;
        end else begin
            poll_q <= phase_s5;
            if (phase_s5) begin
                pend_q <= req_i;
            end
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
// Combinational winner selection for the poll slot.
// Each level runs its own fixed-order search.
// The high level is taken first, subject to the in-service flags.
module irqc_arbiter #(
    parameter int SRC_N = 5,
    parameter int IDX_W = 3
) (
    input  logic [SRC_N-1:0] pend,
    input  logic [SRC_N-1:0] src_en,
    input  logic [SRC_N-1:0] src_hi,
    input  logic             glob_en,
    input  logic             poll,
    input  logic             hold,
    input  logic             act_hi,
    input  logic             act_lo,
    output logic             grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             grant_lvl
);
    import irqc_pkg::*;

    logic open_slot;
    logic allow_hi;
    logic allow_lo;

    // One fixed-order search per level.
    for (genvar lv = 0; lv < 2; lv++) begin : g_lvl
        logic [SRC_N-1:0] cand;
        logic             hit;
        logic [IDX_W-1:0] idx;

        // Find the lowest-numbered enabled pending source of this level.
        always_comb begin
            cand = pend & src_en & ((lv == 1) ? src_hi : ~src_hi);
            hit  = |cand;
            idx  = '0;
            for (int i = SRC_N - 1; i >= 0; i--) begin
                if (cand[i]) idx = IDX_W'(i);
            end
        end
    end

    // Apply the nesting rules and choose between the levels.
    always_comb begin
        open_slot = poll && glob_en && !hold;
        allow_hi  = !act_hi;
        allow_lo  = !act_hi && !act_lo;
        grant     = 1'b0;
        grant_idx = '0;
        grant_lvl = LVL_LOW;
        if (open_slot && g_lvl[1].hit && allow_hi) begin
            grant     = 1'b1;
            grant_idx = g_lvl[1].idx;
            grant_lvl = LVL_HIGH;
        end else if (open_slot && g_lvl[0].hit && allow_lo) begin
            grant     = 1'b1;
            grant_idx = g_lvl[0].idx;
            grant_lvl = LVL_LOW;
        end
    end
endmodule

// File: rtl/irqc_level_track.sv
// In-service flags, one per level.
// A grant sets the flag of its level; a return clears the highest set flag.
// Assumes a grant and a return never fall in the same clock.
module irqc_level_track (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    input  logic grant_lvl,
    input  logic reti,
    output logic act_hi,
    output logic act_lo
);
    import irqc_pkg::*;

    // Set on grant, clear the innermost level on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_hi <= 1'b0;
            act_lo <= 1'b0;
        end else if (grant) begin
            if (irq_lvl_e'(grant_lvl) == LVL_HIGH) act_hi <= 1'b1;
            else                                   act_lo <= 1'b1;
        end else if (reti) begin
            if (act_hi)      act_hi <= 1'b0;
            else if (act_lo) act_lo <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
// Top of the two-level vectored interrupt controller.
// Samples requests on the strobe and arbitrates in the next clock.
// Registers a one-clock call request with its vector.
module irq_vec_ctrl #(
    parameter int          SRC_N      = 5,
    parameter int          CFG_W      = 8,
    parameter int          GLOBAL_BIT = 7,
    parameter int          VEC_W      = 16,
    parameter int          VEC_BASE   = 3,
    parameter int          VEC_STEP   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_s5,
    input  logic [SRC_N-1:0] req_i,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             reti_i,
    output logic             call_req,
    output logic [VEC_W-1:0] call_vec
);
    localparam int IDX_W = (SRC_N > 1) ? $clog2(SRC_N) : 1;

    logic [SRC_N-1:0] src_en;
    logic [SRC_N-1:0] src_hi;
    logic             glob_en;
    logic [SRC_N-1:0] pend_q;
    logic             poll_q;
    logic             act_hi;
    logic             act_lo;
    logic             grant;
    logic [IDX_W-1:0] grant_idx;
    logic             grant_lvl;
    logic             hold;

    assign hold = cfg_wr || reti_i;

    irqc_cfg_regs #(.SRC_N(SRC_N), .CFG_W(CFG_W), .GLOBAL_BIT(GLOBAL_BIT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_sel(cfg_sel),
        .wr_data(cfg_wdata), .src_en(src_en), .glob_en(glob_en), .src_hi(src_hi)
    );

    irqc_sampler #(.SRC_N(SRC_N)) u_smp (
        .clk(clk), .rst_n(rst_n), .phase_s5(phase_s5), .req_i(req_i),
        .pend_q(pend_q), .poll_q(poll_q)
    );

    irqc_arbiter #(.SRC_N(SRC_N), .IDX_W(IDX_W)) u_arb (
        .pend(pend_q), .src_en(src_en), .src_hi(src_hi), .glob_en(glob_en),
        .poll(poll_q), .hold(hold), .act_hi(act_hi), .act_lo(act_lo),
        .grant(grant), .grant_idx(grant_idx), .grant_lvl(grant_lvl)
    );

    irqc_level_track u_lvl (
        .clk(clk), .rst_n(rst_n), .grant(grant), .grant_lvl(grant_lvl),
        .reti(reti_i), .act_hi(act_hi), .act_lo(act_lo)
    );

    // Register the call request and turn the winning index into its vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            call_req <= 1'b0;
            call_vec <= '0;
        end else begin
            call_req <= grant;
            call_vec <= grant ? (VEC_W'(VEC_BASE) + VEC_W'(grant_idx) * VEC_W'(VEC_STEP))
                              : '0;
        end
    end
endmodule

// File: rtl/irqc_checker.sv
// Temporal checks for irq_vec_ctrl, attached with bind.
// Assumes the observed internals come from separate submodules.
module irqc_checker #(
    parameter int SRC_N    = 5,
    parameter int VEC_W    = 16,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             call_req,
    input logic [VEC_W-1:0] call_vec,
    input logic             cfg_wr,
    input logic             reti_i,
    input logic             glob_en,
    input logic             act_hi,
    input logic             act_lo,
    input logic             poll_q
);
    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> $past(glob_en)); // R2
    AST_HI_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> !$past(act_hi)); // R4
    AST_LEVEL_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (act_hi || act_lo)); // R4
    AST_CALL_AFTER_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> $past(poll_q)); // R5
    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> ((int'(call_vec) >= VEC_BASE)
                      && ((int'(call_vec) - VEC_BASE) % VEC_STEP == 0)
                      && ((int'(call_vec) - VEC_BASE) / VEC_STEP < SRC_N))); // R7
    AST_IDLE_RETI: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !act_hi && !act_lo) |=> (!act_hi && !act_lo)); // R8
    AST_QUIET_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_wr || reti_i) |-> !call_req); // R9
    AST_VEC_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !call_req |-> (call_vec == '0)); // R10
endmodule

bind irq_vec_ctrl irqc_checker #(
    .SRC_N(SRC_N), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) chk_i (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_vec(call_vec),
    .cfg_wr(cfg_wr), .reti_i(reti_i), .glob_en(glob_en),
    .act_hi(act_hi), .act_lo(act_lo), .poll_q(poll_q)
);

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cnt = 3'd0;
    logic        phase_s5;
    logic [4:0]  req_i = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        reti_i = 1'b0;
    logic        call_req;
    logic [15:0] call_vec;

    int checks = 0;
    int errors = 0;
    int call_cnt = 0;
    int cycles = 0;
    logic [15:0] last_vec = '0;

    // behavioural reference state
    bit [4:0] m_en, m_pri, m_pend;
    bit       m_glob, m_poll, m_hi, m_lo, exp_call;
    int       exp_vec;

    always #4 clk = ~clk;
    assign phase_s5 = (cnt == 3'd4);

    irq_vec_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .phase_s5(phase_s5), .req_i(req_i),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .reti_i(reti_i), .call_req(call_req), .call_vec(call_vec)
    );

    // machine cycle of six clocks
    always @(posedge clk) cnt <= (cnt == 3'd5) ? 3'd0 : cnt + 3'd1;

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        int win, wlvl;
        if (!rst_n) begin
            m_en = 0; m_pri = 0; m_pend = 0; m_glob = 0; m_poll = 0;
            m_hi = 0; m_lo = 0; exp_call = 0; exp_vec = 0;
        end else begin
            win = -1; wlvl = 0;
            if (m_poll && m_glob && !reti_i && !cfg_wr) begin
                for (int lv = 1; lv >= 0; lv--) begin
                    bit ok;
                    ok = (lv == 1) ? !m_hi : (!m_hi && !m_lo);
                    for (int s = 0; s < 5; s++)
                        if (win < 0 && ok && m_pend[s] && m_en[s] && (m_pri[s] == lv[0])) begin
                            win = s; wlvl = lv;
                        end
                end
            end
            exp_call = (win >= 0);
            exp_vec  = (win >= 0) ? 3 + 8 * win : 0;
            if (win >= 0) begin
                if (wlvl == 1) m_hi = 1; else m_lo = 1;
            end else if (reti_i) begin
                if (m_hi) m_hi = 0; else if (m_lo) m_lo = 0;
            end
            if (cfg_wr) begin
                if (!cfg_sel) begin m_en = cfg_wdata[4:0]; m_glob = cfg_wdata[7]; end
                else m_pri = cfg_wdata[4:0];
            end
            m_poll = phase_s5;
            if (phase_s5) m_pend = req_i;
        end
    end

    // per-clock comparison away from the active edge (R10)
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (call_req !== exp_call || int'(call_vec) != exp_vec) begin
                errors++;
                $display("FAIL R10 clock compare: actual req=%0b vec=%h expected req=%0b vec=%h",
                         call_req, call_vec, exp_call, exp_vec);
            end
            if (call_req) begin call_cnt++; last_vec = call_vec; end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic mc(int n);
        tick(6 * n);
    endtask

    task automatic wr(bit sel, logic [7:0] d);
        cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
        tick(1);
        cfg_wr = 0;
    endtask

    task automatic ret();
        reti_i = 1;
        tick(1);
        reti_i = 0;
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic serve(int vec, string tag);
        int c0;
        c0 = call_cnt;
        mc(2);
        check(call_cnt == c0 + 1 && int'(last_vec) == vec, tag, int'(last_vec), vec);
    endtask

    task automatic quiet(string tag);
        int c0;
        c0 = call_cnt;
        mc(2);
        check(call_cnt == c0, tag, call_cnt - c0, 0);
    endtask

    // watchdog: counts as a failed check and still prints the summary
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL R5 watchdog: actual cycles=%0d expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1;
        #3;
        check(call_req == 0 && call_vec == 0, "R10 reset state", {call_req, call_vec}, 0);
        tick(1);

        // R1 / R7: single external 0 request at low level
        wr(0, 8'h81);
        req_i = 5'b00001;
        serve(16'h0003, "R1 ext0 enabled, vector R7");
        req_i = 0; ret();

        // R2: master enable off
        wr(0, 8'h1F);
        req_i = 5'b11111;
        quiet("R2 master off blocks all");
        req_i = 0;

        // R1: reserved enable bits alone enable nothing
        wr(0, 8'hE0);
        req_i = 5'b11111;
        quiet("R1 reserved enable bits ignored");
        req_i = 0;

        // R6 / R7 / R4: all five at low level, served one by one in order
        wr(1, 8'hE0);
        wr(0, 8'h9F);
        req_i = 5'b11111;
        for (int s = 0; s < 5; s++) begin
            serve(3 + 8 * s, "R6 low-level poll order, R7 vector");
            quiet("R4 low cannot preempt low");
            req_i[s] = 0;
            ret();
        end

        // R3 / R6: serial at high level beats everything
        wr(1, 8'h10);
        req_i = 5'b11111;
        serve(16'h0023, "R3 serial high wins");
        quiet("R4 nothing preempts high");
        req_i[4] = 0;
        ret();
        serve(16'h0003, "R6 low ext0 after high return");
        req_i = 0; ret();

        // R4 / R8: high timer 1 preempts low external 1; nested returns
        wr(1, 8'h08);
        req_i = 5'b00100;
        serve(16'h0013, "R4 low ext1 served");
        req_i = 5'b01000;
        serve(16'h001B, "R4 high tmr1 preempts low");
        req_i = 5'b00001;
        quiet("R4 low blocked while high active");
        ret();
        quiet("R8 first return clears only high");
        ret();
        serve(16'h0003, "R8 second return frees low");
        req_i = 0; ret();

        // R8: idle return leaves nothing behind
        ret();
        req_i = 5'b00010;
        serve(16'h000B, "R8 idle return has no effect");
        req_i = 0; ret();

        // R9: write during the poll clock defers the call one machine cycle
        begin
            int c0;
            while (cnt != 3'd4) tick(1);
            req_i = 5'b00100;
            tick(1);                 // sampling edge passes, now in poll clock
            c0 = call_cnt;
            wr(0, 8'h9F);            // same value, only the timing matters
            tick(4);
            check(call_cnt == c0, "R9 no call from blocked poll", call_cnt - c0, 0);
            mc(1);
            check(call_cnt == c0 + 1 && last_vec == 16'h0013,
                  "R9 call at next machine cycle", int'(last_vec), 16'h0013);
            req_i = 0; ret();
        end

        // R5: a request present only between strobes is missed
        while (cnt != 3'd1) tick(1);
        req_i = 5'b00001;
        tick(1);
        req_i = 0;
        quiet("R5 short request between strobes ignored");

        // R5: exact call latency from the sampling edge
        begin
            while (cnt != 3'd4) tick(1);
            req_i = 5'b10000;
            @(posedge clk);          // sampling edge
            @(posedge clk);          // poll clock ends
            #2;
            check(call_req == 1 && call_vec == 16'h0023, "R5 call two clocks after sample",
                  {call_req, call_vec}, 17'h10023);
            req_i = 0; tick(2); ret();
        end

        mc(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule